// File: doc/BRIEF.md
# Multi-Queue Linked List FIFO

This block keeps several independent first-in first-out queues, called colors, inside one shared data store of DEPTH slots. A second store of the same depth holds one link per slot. The links chain the slots of each color from head to tail, and they also chain the unused slots into a free list. Registers hold a head and a tail pointer for each color, plus the head of the free list and a count of free slots.

Every color always owns one empty slot at its tail. The next value pushed to that color is written into that slot. A push then takes a fresh slot from the free list and links it on as the new reserved tail. A pop reads the head slot of the chosen color and returns that slot to the free list. When a push and an accepted pop fall in the same cycle, the popped slot becomes the pushed color's new reserved tail and the free list is not touched. Because of this, a push is still accepted while the store is full, provided a pop is accepted in the same cycle. The usable capacity is DEPTH minus COLORS entries.

One push and one pop may be presented in each cycle. Popped data and all status flags arrive one cycle after the request.

Top module: `mqf_llfifo`

## Requirements
- R1: After synchronous reset, every bit of `empty_mask` is 1, and `full`, `pop_vld`, `pop_err` and `push_rej` are 0.
- R2: An accepted pop returns the oldest entry of its color on `pop_data`, with `pop_vld` high, in the cycle after the request.
- R3: Each color keeps its own order. Pushes and pops on one color never change the data or order of any other color.
- R4: The total number of stored entries over all colors can reach DEPTH-COLORS. `full` is high, one cycle after the causing operation, exactly when the stored total equals DEPTH-COLORS.
- R5: A push presented while `full` is high, without an accepted pop in the same cycle, is refused. `push_rej` goes high the next cycle, and later pops show that no queue content changed.
- R6: A push presented together with an accepted pop is always accepted, even when `full` is high, and for both the same and a different color. The stored total stays the same.
- R7: A pop of a color that holds no entry is ignored. The next cycle shows `pop_err` high and `pop_vld` low, and the queue state does not change.
- R8: Bit c of `empty_mask` is 0 exactly when color c holds at least one entry. The bit reflects each accepted operation from the following cycle.
- R9: A pop accepted without a push in the same cycle frees one slot, so `full` drops the next cycle if it was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Push request |
| push_color | input | CW | Color of the push |
| push_data | input | DW | Data to push |
| push_rej | output | 1 | Previous cycle's push was refused |
| pop_valid | input | 1 | Pop request |
| pop_color | input | CW | Color to pop |
| pop_data | output | DW | Head data of the previous cycle's accepted pop |
| pop_vld | output | 1 | `pop_data` is valid |
| pop_err | output | 1 | Previous cycle's pop hit an empty color |
| empty_mask | output | COLORS | Per-color empty flags |
| full | output | 1 | No free slot remains |

## Verification
Push and pop are the two functions that can occur in the same cycle, and they interact through slot handoff. The bench provokes this by applying every combination of push color and pop color, with each request either present or absent, at every fill level from empty to full. Fill levels are reached by sequences of single operations. A reference model updates on pop first and then on push. Each result is judged on whether the push was accepted (including when full), on the popped value, and on the empty and full flags that follow. Further directed runs pop and push the same color while it holds a single entry, and push to a different color while the store is full.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
  // Pointer or index width for n items, never below one bit.
  function automatic int ptr_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/mqf_data_ram.sv
module mqf_data_ram #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Synchronous write and registered read, the shape block RAM infers from.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mqf_link_ram.sv
module mqf_link_ram #(
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [AW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [AW-1:0] rdata_b
);
  logic [AW-1:0] link [DEPTH];

  // Reset chains every slot to its successor; the free list uses the
  // slots past the reserved ones, and the rest are rewritten before use.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) link[i] <= AW'((i + 1) % DEPTH);
    end else if (we) begin
      link[waddr] <= wdata;
    end
  end

  assign rdata_a = link[raddr_a];
  assign rdata_b = link[raddr_b];
endmodule

// File: rtl/mqf_queue_regs.sv
module mqf_queue_regs #(
  parameter int COLORS = 3,
  parameter int AW     = 4,
  parameter int CW     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_ok,
  input  logic [CW-1:0]              push_color,
  input  logic [AW-1:0]              new_tail,
  input  logic                       pop_ok,
  input  logic [CW-1:0]              pop_color,
  input  logic [AW-1:0]              pop_next,
  output logic [COLORS-1:0][AW-1:0]  heads,
  output logic [COLORS-1:0][AW-1:0]  tails,
  output logic [COLORS-1:0]          empties
);
  for (genvar c = 0; c < COLORS; c++) begin : g_color
    logic push_here, pop_here;
    assign push_here = push_ok && (push_color == CW'(c));
    assign pop_here  = pop_ok  && (pop_color  == CW'(c));

    // Color c starts with slot c as its reserved tail.
    always_ff @(posedge clk) begin
      if (rst) begin
        heads[c] <= AW'(c);
        tails[c] <= AW'(c);
      end else begin
        if (pop_here)  heads[c] <= pop_next;
        if (push_here) tails[c] <= new_tail;
      end
    end

    assign empties[c] = (heads[c] == tails[c]);
  end
endmodule

// File: rtl/mqf_llfifo.sv
module mqf_llfifo #(
  parameter int COLORS = 3,
  parameter int DEPTH  = 12,
  parameter int DW     = 8,
  localparam int AW    = mqf_pkg::ptr_w(DEPTH),
  localparam int CW    = mqf_pkg::ptr_w(COLORS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [CW-1:0]     push_color,
  input  logic [DW-1:0]     push_data,
  output logic              push_rej,
  input  logic              pop_valid,
  input  logic [CW-1:0]     pop_color,
  output logic [DW-1:0]     pop_data,
  output logic              pop_vld,
  output logic              pop_err,
  output logic [COLORS-1:0] empty_mask,
  output logic              full
);
  localparam int CNTW      = $clog2(DEPTH + 1);
  localparam int FREE_INIT = DEPTH - COLORS;

  logic [COLORS-1:0][AW-1:0] heads, tails;
  logic [AW-1:0]   free_head, free_next;
  logic [CNTW-1:0] free_cnt, free_cnt_nxt;
  logic [AW-1:0]   pop_head, pop_next, push_tail, new_tail;
  logic            pop_empty, pop_in_rng, push_in_rng;
  logic            pop_ok, push_ok;
  logic            lk_we;
  logic [AW-1:0]   lk_waddr, lk_wdata;

  // Select the pointers of the requested colors.
  always_comb begin
    pop_head   = '0;
    push_tail  = '0;
    pop_empty  = 1'b1;
    pop_in_rng  = 1'b0;
    push_in_rng = 1'b0;
    for (int c = 0; c < COLORS; c++) begin
      if (pop_color == CW'(c)) begin
        pop_head   = heads[c];
        pop_empty  = empty_mask[c];
        pop_in_rng = 1'b1;
      end
      if (push_color == CW'(c)) begin
        push_tail   = tails[c];
        push_in_rng = 1'b1;
      end
    end
  end

  assign pop_ok   = pop_valid && pop_in_rng && !pop_empty;
  assign push_ok  = push_valid && push_in_rng && ((free_cnt != '0) || pop_ok);
  // Handoff: a popped slot goes straight to the pushing color.
  assign new_tail = pop_ok ? pop_head : free_head;

  // One link write per cycle: either extend a color or return a slot.
  always_comb begin
    lk_we    = 1'b0;
    lk_waddr = push_tail;
    lk_wdata = new_tail;
    if (push_ok) begin
      lk_we = 1'b1;
    end else if (pop_ok) begin
      lk_we    = 1'b1;
      lk_waddr = pop_head;
      lk_wdata = free_head;
    end
  end

  always_comb begin
    free_cnt_nxt = free_cnt;
    if (push_ok && !pop_ok)      free_cnt_nxt = free_cnt - 1'b1;
    else if (pop_ok && !push_ok) free_cnt_nxt = free_cnt + 1'b1;
  end

  mqf_link_ram #(.DEPTH(DEPTH), .AW(AW)) u_link (
    .clk     (clk),
    .rst     (rst),
    .we      (lk_we),
    .waddr   (lk_waddr),
    .wdata   (lk_wdata),
    .raddr_a (pop_head),
    .rdata_a (pop_next),
    .raddr_b (free_head),
    .rdata_b (free_next)
  );

  mqf_data_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_data (
    .clk   (clk),
    .we    (push_ok),
    .waddr (push_tail),
    .wdata (push_data),
    .re    (pop_ok),
    .raddr (pop_head),
    .rdata (pop_data)
  );

  mqf_queue_regs #(.COLORS(COLORS), .AW(AW), .CW(CW)) u_q (
    .clk        (clk),
    .rst        (rst),
    .push_ok    (push_ok),
    .push_color (push_color),
    .new_tail   (new_tail),
    .pop_ok     (pop_ok),
    .pop_color  (pop_color),
    .pop_next   (pop_next),
    .heads      (heads),
    .tails      (tails),
    .empties    (empty_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      free_head <= AW'(COLORS % DEPTH);
      free_cnt  <= CNTW'(FREE_INIT);
      full      <= (FREE_INIT == 0);
      pop_vld   <= 1'b0;
      pop_err   <= 1'b0;
      push_rej  <= 1'b0;
    end else begin
      if (push_ok && !pop_ok)      free_head <= free_next;
      else if (pop_ok && !push_ok) free_head <= pop_head;
      free_cnt <= free_cnt_nxt;
      full     <= (free_cnt_nxt == '0);
      pop_vld  <= pop_ok;
      pop_err  <= pop_valid && !pop_ok;
      push_rej <= push_valid && !push_ok;
    end
  end
endmodule

// File: rtl/mqf_llfifo_chk.sv
module mqf_llfifo_chk #(
  parameter int COLORS = 3,
  parameter int CW     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              push_valid,
  input logic [CW-1:0]     push_color,
  input logic              push_rej,
  input logic              pop_valid,
  input logic [CW-1:0]     pop_color,
  input logic              pop_vld,
  input logic              pop_err,
  input logic [COLORS-1:0] empty_mask,
  input logic              full
);
  logic pop_hits_data, pop_hits_empty, push_in_rng;
  always_comb begin
    pop_hits_data  = 1'b0;
    pop_hits_empty = 1'b0;
    push_in_rng    = 1'b0;
    for (int c = 0; c < COLORS; c++) begin
      if (pop_valid && pop_color == CW'(c)) begin
        pop_hits_data  = !empty_mask[c];
        pop_hits_empty = empty_mask[c];
      end
      if (push_color == CW'(c)) push_in_rng = 1'b1;
    end
  end

  // R7
  pop_empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    pop_hits_empty |=> (pop_err && !pop_vld));

  // R2
  pop_latency_chk: assert property (@(posedge clk) disable iff (rst)
    pop_hits_data |=> (pop_vld && !pop_err));

  // R5
  full_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && full && !pop_hits_data) |=> push_rej);

  // R6
  handoff_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && push_in_rng && pop_hits_data) |=> !push_rej);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!push_valid && !pop_valid) |=> ($stable(empty_mask) && $stable(full)));

  // R7
  vld_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop_vld && pop_err));
endmodule

bind mqf_llfifo mqf_llfifo_chk #(.COLORS(COLORS), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .push_valid (push_valid),
  .push_color (push_color),
  .push_rej   (push_rej),
  .pop_valid  (pop_valid),
  .pop_color  (pop_color),
  .pop_vld    (pop_vld),
  .pop_err    (pop_err),
  .empty_mask (empty_mask),
  .full       (full)
);

// File: tb/sim_mqf_llfifo.sv
module sim_mqf_llfifo;
  localparam int C  = 3;
  localparam int D  = 12;
  localparam int W  = 8;
  localparam int CW = 2;
  localparam int CAP = D - C;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0, pop_valid = 1'b0;
  logic [CW-1:0] push_color = '0, pop_color = '0;
  logic [W-1:0]  push_data = '0;
  logic push_rej, pop_vld, pop_err, full;
  logic [W-1:0] pop_data;
  logic [C-1:0] empty_mask;

  int nvec = 0, nfail = 0;
  bit done = 0;
  int mq [C][D];
  int mcnt [C];
  int dseed = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mqf_llfifo #(.COLORS(C), .DEPTH(D), .DW(W)) u0 (
    .clk(clk), .rst(rst),
    .push_valid(push_valid), .push_color(push_color), .push_data(push_data),
    .push_rej(push_rej),
    .pop_valid(pop_valid), .pop_color(pop_color), .pop_data(pop_data),
    .pop_vld(pop_vld), .pop_err(pop_err),
    .empty_mask(empty_mask), .full(full)
  );

  task automatic chk(input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int total();
    int t = 0;
    for (int c = 0; c < C; c++) t += mcnt[c];
    return t;
  endfunction

  // One cycle: drive at a falling edge, model, check at the next falling edge.
  task automatic step(input bit pv, input int pc, input bit ov, input int oc,
                      input string tag);
    bit pop_acc, push_acc;
    int exp_d = 0;
    logic [W-1:0] d;
    dseed = (dseed * 37 + 11) % 251;
    d = W'(dseed);
    pop_acc  = ov && (mcnt[oc] > 0);
    push_acc = pv && ((CAP - total()) > 0 || pop_acc);
    if (pop_acc) exp_d = mq[oc][0];
    push_valid = pv; push_color = CW'(pc); push_data = d;
    pop_valid = ov;  pop_color = CW'(oc);
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0; pop_valid = 1'b0;
    if (pop_acc) begin
      for (int i = 0; i < D - 1; i++) mq[oc][i] = mq[oc][i+1];
      mcnt[oc]--;
    end
    if (push_acc) begin
      mq[pc][mcnt[pc]] = int'(d);
      mcnt[pc]++;
    end
    chk({"R2 pop_vld ", tag}, int'(pop_vld), int'(pop_acc));
    if (pop_acc) chk({"R2 R3 pop_data ", tag}, int'(pop_data), exp_d);
    chk({"R7 pop_err ", tag}, int'(pop_err), int'(ov && !pop_acc));
    chk({"R5 R6 push_rej ", tag}, int'(push_rej), int'(pv && !push_acc));
    for (int c = 0; c < C; c++)
      chk({"R8 empty_mask ", tag}, int'(empty_mask[c]), int'(mcnt[c] == 0));
    chk({"R4 R9 full ", tag}, int'(full), int'(total() == CAP));
  endtask

  task automatic set_level(input int lvl);
    while (total() > lvl) begin
      for (int c = 0; c < C; c++)
        if (mcnt[c] > 0 && total() > lvl) step(0, 0, 1, c, "level drain");
    end
    while (total() < lvl) step(1, total() % C, 0, 0, "level fill");
  endtask

  initial begin
    for (int c = 0; c < C; c++) mcnt[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 empty_mask", int'(empty_mask), (1 << C) - 1);
    chk("R1 full", int'(full), 0);
    chk("R1 pop_vld", int'(pop_vld), 0);
    chk("R1 pop_err", int'(pop_err), 0);
    chk("R1 push_rej", int'(push_rej), 0);

    // R3 interleaved colors
    for (int i = 0; i < 6; i++) step(1, i % C, 0, 0, "R3 fill");
    for (int i = 0; i < 6; i++) step(0, 0, 1, (i * 2) % C, "R3 drain");

    // R4 fill to capacity, R5 refuse, R6 handoff, R9 release
    set_level(CAP);
    step(1, 1, 0, 0, "R5 push on full");
    step(1, 2, 0, 0, "R5 push on full");
    step(1, 0, 1, 0, "R6 same color on full");
    step(1, 2, 1, 1, "R6 other color on full");
    step(0, 0, 1, 2, "R9 pop alone");
    step(1, 1, 0, 0, "R4 refill");

    // R7 pop of empty colors
    set_level(0);
    for (int c = 0; c < C; c++) step(0, 0, 1, c, "R7 pop empty");
    step(1, 1, 1, 1, "R7 push with empty pop");

    // R6 single-entry same-color push and pop
    for (int c = 0; c < C; c++) begin
      set_level(0);
      step(1, c, 0, 0, "R6 prime");
      step(1, c, 1, c, "R6 one entry");
      step(0, 0, 1, c, "R6 after");
    end

    // Near-exhaustive sweep: every request combination at every fill level.
    for (int lvl = 0; lvl <= CAP; lvl++)
      for (int pv = 0; pv < 2; pv++)
        for (int pc = 0; pc < C; pc++)
          for (int ov = 0; ov < 2; ov++)
            for (int oc = 0; oc < C; oc++) begin
              set_level(lvl);
              step(bit'(pv), pc, bit'(ov), oc, "R6 sweep");
            end

    set_level(0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule